// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block walks a DDR memory array through its power-up ritual once reset is released and a start pulse arrives. It plays a fixed script: waits, precharges, mode-register loads and a train of auto refreshes. Each memory command is delivered to every populated rank, one rank per clock. The rank layout is given as a table of cumulative end boundaries in 32 MB units. A rank counts as populated when its end lies above the end of the rank before it. The strobe's address points into that rank. For the two mode-register commands, the address also carries the mode word, folded into host address bits.

Waits are measured in units of `UNIT_TICKS` pulses on a free-running tick input. With the default of 200 ticks of a 1 us tick, one unit is 200 us. A test build shortens the unit. After the last refresh the block reloads the operating mode, switches the command mode to normal, raises a sticky init-complete flag and then idles out a final settling wait.

Top module: `ddrInitSeq`

## Requirements
- R1: After reset, `cmdMode` is 0 (self-refresh code), `cmdStrobe` is 0 and `initDone` is 0.
- R2: Command codes are NOP 1, precharge-all 2, MRS 3, EMRS 4, auto refresh 6 and normal 7. The issue order is NOP, precharge-all, EMRS, MRS, precharge-all, `REFRESH_COUNT` (default 8) auto refreshes, MRS, normal.
- R3: A wait of n units lasts n×`UNIT_TICKS` clock edges on which `tickIn` is high. Edges without a tick do not count. The script waits 2 units before the NOP. It waits 3 units after the first NOP, after each of the first two precharges, after the EMRS, after every refresh and after the normal command. It waits 5 units after `initDone` rises.
- R4: The DLL-reset MRS is followed directly by the next precharge-all, and the final MRS directly by the normal command, with no wait between them.
- R5: The mode words are as follows. EMRS carries 0x000 (DLL enabled). The first MRS carries 0x16A. The second MRS carries 0x06A. These come from burst length 4 (code 010 in bits 2:0), interleaved order (bit 3 = 1), CAS latency 2.5 (code 110 in bits 6:4) and DLL reset (bit 8).
- R6: For MRS and EMRS, mode bit 11 appears at address bit 13, mode bits 9:0 at address bits 12:3, and address bits 2:0 and 24:14 are 0. Every other command has a zero offset.
- R7: For each strobed command, `cmdMode` takes the new code one cycle before the rank scan. Ranks are then visited in index order, one per cycle, with a running start that begins at 0. A rank whose end exceeds the running start gets one `cmdStrobe` cycle at address start×2^25 + offset, and the start moves to that end. Other ranks get no strobe.
- R8: The normal command changes `cmdMode` to 7 and produces no strobe.
- R9: `initDone` rises one cycle after the 3-unit wait that follows the normal command. It stays high until reset, and no strobe follows it.
- R10: `start` has no effect while the script is running or after it has finished. Only a reset re-arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the power-up script (idle only) |
| tickIn | input | 1 | Delay tick, one pulse per sub-unit time step |
| rankEnd | input | NUM_RANKS×BOUND_W | Cumulative rank end boundaries, rank i at bits i×BOUND_W upward, 32 MB units |
| cmdMode | output | 3 | Current command mode code |
| cmdStrobe | output | 1 | One-cycle command issue to a rank |
| cmdAddr | output | BOUND_W+UNIT_SHIFT | Target address of the strobed command |
| initDone | output | 1 | Initialization complete, sticky |

## Verification
The bench drives rank tables with an empty rank between populated ones, tables that are entirely empty, and tables whose top boundary is at the maximum value. A wrong comparison or an un-updated running start would strobe empty ranks or compute addresses from the wrong base. Gating the tick to every third cycle exposes a wait counter that counts clocks instead of ticks, because every later output would arrive early. Start pulses mid-script and after completion catch a sequencer that restarts. The per-cycle comparison catches any wait inserted after the DLL-reset MRS, and any strobe during the normal command.

// File: rtl/ddrInitPkg.sv
package ddrInitPkg;

  typedef enum logic [2:0] {
    CMD_SELF_REFRESH = 3'd0,
    CMD_NOP          = 3'd1,
    CMD_PRECHARGE    = 3'd2,
    CMD_MRS          = 3'd3,
    CMD_EMRS         = 3'd4,
    CMD_REFRESH      = 3'd6,
    CMD_NORMAL       = 3'd7
  } cmdCodeE;

  typedef enum logic [1:0] {
    STEP_WAIT = 2'd0,
    STEP_CMD  = 2'd1,
    STEP_DONE = 2'd2,
    STEP_END  = 2'd3
  } stepKindE;

  localparam int MODE_W    = 12;
  localparam int OFFSET_W  = 14;
  localparam int UNITS_W   = 3;

  // burst 4 (010), interleaved (bit 3), CAS 2.5 (110 at 6:4)
  localparam logic [MODE_W-1:0] MODE_OPERATE   = 12'h06A;
  localparam logic [MODE_W-1:0] MODE_DLL_RESET = 12'h100;
  localparam logic [MODE_W-1:0] EXT_DLL_ON     = 12'h000;

  typedef struct packed {
    stepKindE            kind;
    cmdCodeE             code;
    logic [MODE_W-1:0]   modeBits;
    logic [UNITS_W-1:0]  units;
  } stepT;

  typedef struct packed {
    logic                loadMode;
    cmdCodeE             code;
    logic [MODE_W-1:0]   modeBits;
    logic                scanStep;
    logic                setDone;
  } ctrlStrobeT;

  function automatic logic [OFFSET_W-1:0] foldMode(input logic [MODE_W-1:0] m);
    return {m[11], m[9:0], 3'b000};
  endfunction

  function automatic logic carriesMode(input cmdCodeE c);
    return (c == CMD_MRS) || (c == CMD_EMRS);
  endfunction

endpackage

// File: rtl/ddrInitCtrl.sv
module ddrInitCtrl
  import ddrInitPkg::*;
#(
  parameter int UNIT_TICKS    = 200,
  parameter int REFRESH_COUNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tickIn,
  input  logic       lastRank,
  output ctrlStrobeT strobes
);

  localparam int MAX_UNITS  = 5;
  localparam int REF_FIRST  = 10;
  localparam int TAIL_FIRST = REF_FIRST + 2 * REFRESH_COUNT;
  localparam int SCRIPT_LEN = TAIL_FIRST + 6;
  localparam int PC_W       = $clog2(SCRIPT_LEN + 1);
  localparam int WAIT_W     = $clog2(MAX_UNITS * UNIT_TICKS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_WAIT, ST_SCAN, ST_FINISH
  } seqStateE;

  seqStateE            stateQ;
  logic [PC_W-1:0]     pcQ;
  logic [WAIT_W-1:0]   waitQ;
  stepT                curStep;

  function automatic stepT mkWait(input int n);
    stepT s;
    s.kind = STEP_WAIT; s.code = CMD_NOP; s.modeBits = '0; s.units = UNITS_W'(n);
    return s;
  endfunction

  function automatic stepT mkCmd(input cmdCodeE c, input logic [MODE_W-1:0] m);
    stepT s;
    s.kind = STEP_CMD; s.code = c; s.modeBits = m; s.units = '0;
    return s;
  endfunction

  function automatic stepT mkKind(input stepKindE k);
    stepT s;
    s.kind = k; s.code = CMD_NOP; s.modeBits = '0; s.units = '0;
    return s;
  endfunction

  function automatic stepT stepAt(input logic [PC_W-1:0] p);
    int i;
    i = int'(p);
    if (i < REF_FIRST) begin
      case (i)
        0:       return mkWait(2);
        1:       return mkCmd(CMD_NOP, '0);
        2:       return mkWait(3);
        3:       return mkCmd(CMD_PRECHARGE, '0);
        4:       return mkWait(3);
        5:       return mkCmd(CMD_EMRS, EXT_DLL_ON);
        6:       return mkWait(3);
        7:       return mkCmd(CMD_MRS, MODE_OPERATE | MODE_DLL_RESET);
        8:       return mkCmd(CMD_PRECHARGE, '0);
        default: return mkWait(3);
      endcase
    end else if (i < TAIL_FIRST) begin
      if (((i - REF_FIRST) % 2) == 0) return mkCmd(CMD_REFRESH, '0);
      return mkWait(3);
    end else begin
      case (i - TAIL_FIRST)
        0:       return mkCmd(CMD_MRS, MODE_OPERATE);
        1:       return mkCmd(CMD_NORMAL, '0);
        2:       return mkWait(3);
        3:       return mkKind(STEP_DONE);
        4:       return mkWait(MAX_UNITS);
        default: return mkKind(STEP_END);
      endcase
    end
  endfunction

  assign curStep = stepAt(pcQ);

  always_comb begin
    strobes.loadMode = (stateQ == ST_EXEC) && (curStep.kind == STEP_CMD);
    strobes.code     = curStep.code;
    strobes.modeBits = curStep.modeBits;
    strobes.scanStep = (stateQ == ST_SCAN);
    strobes.setDone  = (stateQ == ST_EXEC) && (curStep.kind == STEP_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pcQ    <= '0;
      waitQ  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            pcQ    <= '0;
            stateQ <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          case (curStep.kind)
            STEP_WAIT: begin
              waitQ  <= WAIT_W'(curStep.units) * WAIT_W'(UNIT_TICKS);
              stateQ <= ST_WAIT;
            end
            STEP_CMD: begin
              if (curStep.code == CMD_NORMAL) pcQ <= pcQ + 1'b1;
              else                            stateQ <= ST_SCAN;
            end
            STEP_DONE: pcQ <= pcQ + 1'b1;
            default:   stateQ <= ST_FINISH;
          endcase
        end
        ST_WAIT: begin
          if (tickIn) begin
            if (waitQ == WAIT_W'(1)) begin
              pcQ    <= pcQ + 1'b1;
              stateQ <= ST_EXEC;
            end else begin
              waitQ <= waitQ - 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (lastRank) begin
            pcQ    <= pcQ + 1'b1;
            stateQ <= ST_EXEC;
          end
        end
        default: stateQ <= ST_FINISH;
      endcase
    end
  end

endmodule

// File: rtl/ddrInitDatapath.sv
module ddrInitDatapath
  import ddrInitPkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int BOUND_W    = 8,
  parameter int UNIT_SHIFT = 25
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobeT                    strobes,
  input  logic [NUM_RANKS*BOUND_W-1:0]  rankEnd,
  output logic                          lastRank,
  output logic [2:0]                    cmdMode,
  output logic                          cmdStrobe,
  output logic [BOUND_W+UNIT_SHIFT-1:0] cmdAddr,
  output logic                          initDone
);

  localparam int ADDR_W = BOUND_W + UNIT_SHIFT;
  localparam int IDX_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;

  logic [BOUND_W-1:0]  endArr [NUM_RANKS];
  logic [IDX_W-1:0]    rankIdxQ;
  logic [BOUND_W-1:0]  runStartQ;
  logic [OFFSET_W-1:0] offsetQ;
  logic [BOUND_W-1:0]  curEnd;
  logic                rankHit;
  logic [ADDR_W-1:0]   rankAddr;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_unpack
    assign endArr[g] = rankEnd[g*BOUND_W +: BOUND_W];
  end

  assign curEnd   = endArr[rankIdxQ];
  assign rankHit  = curEnd > runStartQ;
  assign rankAddr = {runStartQ, {UNIT_SHIFT{1'b0}}} + ADDR_W'(offsetQ);
  assign lastRank = (rankIdxQ == IDX_W'(NUM_RANKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdMode   <= 3'(CMD_SELF_REFRESH);
      cmdStrobe <= 1'b0;
      cmdAddr   <= '0;
      initDone  <= 1'b0;
      rankIdxQ  <= '0;
      runStartQ <= '0;
      offsetQ   <= '0;
    end else begin
      cmdStrobe <= 1'b0;
      if (strobes.loadMode) begin
        cmdMode   <= 3'(strobes.code);
        offsetQ   <= carriesMode(strobes.code) ? foldMode(strobes.modeBits) : '0;
        rankIdxQ  <= '0;
        runStartQ <= '0;
      end
      if (strobes.scanStep) begin
        if (rankHit) begin
          cmdStrobe <= 1'b1;
          cmdAddr   <= rankAddr;
          runStartQ <= curEnd;
        end
        rankIdxQ <= rankIdxQ + 1'b1;
      end
      if (strobes.setDone) initDone <= 1'b1;
    end
  end

endmodule

// File: rtl/ddrInitSeq.sv
module ddrInitSeq
  import ddrInitPkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int BOUND_W       = 8,
  parameter int UNIT_SHIFT    = 25,
  parameter int UNIT_TICKS    = 200,
  parameter int REFRESH_COUNT = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          tickIn,
  input  logic [NUM_RANKS*BOUND_W-1:0]  rankEnd,
  output logic [2:0]                    cmdMode,
  output logic                          cmdStrobe,
  output logic [BOUND_W+UNIT_SHIFT-1:0] cmdAddr,
  output logic                          initDone
);

  ctrlStrobeT ctrlStrobes;
  logic       lastRank;

  ddrInitCtrl #(
    .UNIT_TICKS    (UNIT_TICKS),
    .REFRESH_COUNT (REFRESH_COUNT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tickIn   (tickIn),
    .lastRank (lastRank),
    .strobes  (ctrlStrobes)
  );

  ddrInitDatapath #(
    .NUM_RANKS  (NUM_RANKS),
    .BOUND_W    (BOUND_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (ctrlStrobes),
    .rankEnd   (rankEnd),
    .lastRank  (lastRank),
    .cmdMode   (cmdMode),
    .cmdStrobe (cmdStrobe),
    .cmdAddr   (cmdAddr),
    .initDone  (initDone)
  );

endmodule

// File: rtl/ddrInitSeqChk.sv
module ddrInitSeqChk #(
  parameter int BOUND_W    = 8,
  parameter int UNIT_SHIFT = 25
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [2:0]                    cmdMode,
  input logic                          cmdStrobe,
  input logic [BOUND_W+UNIT_SHIFT-1:0] cmdAddr,
  input logic                          initDone
);

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMode != 3'd5));

  a_r8_no_strobe_in_normal: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> (cmdMode != 3'd7) && (cmdMode != 3'd0));

  a_r6_addr_gaps_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> (cmdAddr[2:0] == 3'b000) && (cmdAddr[UNIT_SHIFT-1:14] == '0));

  a_r6_plain_cmd_no_offset: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && (cmdMode != 3'd3) && (cmdMode != 3'd4)) |-> (cmdAddr[13:0] == '0));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !cmdStrobe);

  a_r8_done_after_normal: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (cmdMode == 3'd7));

endmodule

bind ddrInitSeq ddrInitSeqChk #(
  .BOUND_W    (BOUND_W),
  .UNIT_SHIFT (UNIT_SHIFT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cmdMode   (cmdMode),
  .cmdStrobe (cmdStrobe),
  .cmdAddr   (cmdAddr),
  .initDone  (initDone)
);

// File: tb/ddrInitSeq_tb_top.sv
module ddrInitSeq_tb_top;

  localparam int NR = 4;
  localparam int BW = 8;
  localparam int SH = 25;
  localparam int UT = 4;
  localparam int NREF = 8;
  localparam int AW = BW + SH;

  localparam int K_MODE = 0, K_SLOT = 1, K_ENTER = 2, K_WAIT = 3, K_DONE = 4, K_END = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic tickIn = 1'b0;
  logic [NR*BW-1:0] rankEnd = '0;
  logic [2:0] cmdMode;
  logic cmdStrobe;
  logic [AW-1:0] cmdAddr;
  logic initDone;

  always #2 clk = ~clk;

  ddrInitSeq #(.NUM_RANKS(NR), .BOUND_W(BW), .UNIT_SHIFT(SH),
               .UNIT_TICKS(UT), .REFRESH_COUNT(NREF)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tickIn(tickIn), .rankEnd(rankEnd),
    .cmdMode(cmdMode), .cmdStrobe(cmdStrobe), .cmdAddr(cmdAddr), .initDone(initDone));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit ended = 0;

  int  rk [NR];
  int  tickDiv = 1;
  int  tickCnt = 0;
  int  qKind [$];
  longint qVal [$];
  longint qAddr [$];
  int  expMode = 0;
  bit  expStrobe = 0;
  longint expAddr = 0;
  bit  expDone = 0;
  bit  finished = 0;
  int  expStrobes = 0, obsStrobes = 0, obsNormalStrobes = 0, obsMrsReset = 0, expMrsReset = 0;
  int  obsAfter = 0;
  bit  afterWin = 0;

  function automatic longint fold(input longint m);
    return (((m >> 11) & 1) << 13) | ((m & 'h3FF) << 3);
  endfunction

  task automatic push(input int k, input longint v, input longint a);
    qKind.push_back(k); qVal.push_back(v); qAddr.push_back(a);
  endtask

  task automatic pushWait(input int units);
    push(K_ENTER, 0, 0);
    push(K_WAIT, units * UT, 0); // R3: waits count only ticked edges
  endtask

  task automatic pushCmd(input int code, input longint modeWord);
    longint off = (code == 3 || code == 4) ? fold(modeWord) : 0; // R6
    longint run = 0;
    push(K_MODE, code, 0);                                         // R7: mode one cycle ahead
    for (int i = 0; i < NR; i++) begin
      if (rk[i] > run) begin
        push(K_SLOT, 1, (run << SH) + off);
        run = rk[i];
        expStrobes++;
        if (code == 3 && modeWord == 'h16A) expMrsReset++;
      end else push(K_SLOT, 0, 0);
    end
  endtask

  task automatic buildScript();
    pushWait(2);
    pushCmd(1, 0); pushWait(3);        // R2 order
    pushCmd(2, 0); pushWait(3);
    pushCmd(4, 'h000); pushWait(3);    // R5 EMRS word
    pushCmd(3, 'h16A);                 // R5 DLL reset word
    pushCmd(2, 0); pushWait(3);        // R4 no wait before precharge
    for (int r = 0; r < NREF; r++) begin pushCmd(6, 0); pushWait(3); end
    pushCmd(3, 'h06A);                 // R4 no wait before normal
    push(K_MODE, 7, 0);                // R8 normal: no rank slots
    pushWait(3);
    push(K_DONE, 0, 0);                // R9
    pushWait(5);
    push(K_END, 0, 0);
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      qKind.delete(); qVal.delete(); qAddr.delete();
      expMode = 0; expStrobe = 0; expDone = 0; finished = 0;
    end else begin
      expStrobe = 0;
      if (qKind.size() == 0) begin
        if (!finished && start) buildScript(); // R10: idle only
      end else begin
        case (qKind[0])
          K_MODE: begin expMode = int'(qVal[0]); void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front()); end
          K_SLOT: begin
            if (qVal[0] != 0) begin expStrobe = 1; expAddr = qAddr[0]; end
            void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front());
          end
          K_WAIT: begin
            if (tickIn) qVal[0] = qVal[0] - 1;
            if (qVal[0] == 0) begin void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front()); end
          end
          K_DONE: begin expDone = 1; void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front()); end
          K_END: begin finished = 1; void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front()); end
          default: begin void'(qKind.pop_front()); void'(qVal.pop_front()); void'(qAddr.pop_front()); end
        endcase
      end
    end
  end

  // tick source, driven away from the active edge
  always @(negedge clk) begin
    tickCnt++;
    tickIn = (tickDiv <= 1) ? 1'b1 : ((tickCnt % tickDiv) == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !ended) begin
      check(int'(cmdMode) == expMode, "R2 cmdMode", cmdMode, expMode);
      check(cmdStrobe == expStrobe, "R7 cmdStrobe", cmdStrobe, expStrobe);
      check(initDone == expDone, "R9 initDone", initDone, expDone);
      if (expStrobe && cmdStrobe) check(64'(cmdAddr) == expAddr, "R6 cmdAddr", 64'(cmdAddr), expAddr);
      if (cmdStrobe) begin
        obsStrobes++;
        if (cmdMode == 3'd7) obsNormalStrobes++;
        if (cmdMode == 3'd3 && cmdAddr[13:0] == 14'hB50) obsMrsReset++;
        if (afterWin) obsAfter++;
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    ended = 1;
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !ended) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runOne(input int e0, input int e1, input int e2, input int e3,
                        input int div, input bit midStart);
    rstN = 1'b0;
    rk[0] = e0; rk[1] = e1; rk[2] = e2; rk[3] = e3;
    for (int i = 0; i < NR; i++) rankEnd[i*BW +: BW] = BW'(rk[i]);
    tickDiv = div;
    expStrobes = 0; obsStrobes = 0; obsNormalStrobes = 0; obsMrsReset = 0; expMrsReset = 0; obsAfter = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmdMode == 3'd0, "R1 reset cmdMode", cmdMode, 0);
    check(cmdStrobe == 1'b0, "R1 reset cmdStrobe", cmdStrobe, 0);
    check(initDone == 1'b0, "R1 reset initDone", initDone, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    pulseStart();
    if (midStart) begin
      repeat (150) @(negedge clk);
      pulseStart(); // R10 ignored while running
    end
    while (!finished) @(negedge clk);
    afterWin = 1;
    pulseStart();   // R10 ignored after completion
    repeat (40) @(negedge clk);
    afterWin = 0;
    check(obsAfter == 0, "R10 strobes after completion", obsAfter, 0);
    check(obsStrobes == expStrobes, "R7 strobe total", obsStrobes, expStrobes);
    check(obsNormalStrobes == 0, "R8 strobes in normal mode", obsNormalStrobes, 0);
    check(obsMrsReset == expMrsReset, "R5 DLL-reset MRS offset count", obsMrsReset, expMrsReset);
    check(initDone == 1'b1, "R9 initDone held", initDone, 1);
  endtask

  initial begin
    runOne(4, 4, 12, 16, 1, 1'b1);     // empty rank 1 between populated ones
    runOne(0, 0, 0, 0, 1, 1'b0);       // no rank populated
    runOne(200, 0, 255, 255, 3, 1'b1); // decreasing end, top boundary, gated tick
    finishRun();
  end

endmodule